// File: doc/BRIEF.md
# RS485 Transmit Direction Controller

This block pairs a small 8N1 serial transmitter with hardware control of an RS485 line driver. The transmitter's RTS pin serves as the driver-enable output. Software writes bytes into a one-byte holding register. The block then raises the driver enable, sends each frame, and keeps the bus driven long enough for the stop bit to clear the transceiver. No software timing is needed for any of this.

A simple write port sets up the block through three locations:

| Offset | Contents |
|--------|----------|
| 0x00 | transmit data |
| 0x08 | 16-bit bit-time divisor |
| 0x20 | mode register |

In the mode register, bit 4 turns automatic direction control on, bit 3 picks the output polarity, and bit 0 picks 13x instead of 16x oversampling. When automatic control is off, RTS simply passes through the ordinary modem-control value. The `tx_idle_o` status output tells software when the line has been fully handed back.

Top module: `rs485_dir_tx`

## Requirements
- R1: After reset, `txd_o` is 1 and `tx_idle_o` is 1. All mode bits are zero, so `rts_o` equals `mcr_rts_i`.
- R2: While mode bit 4 is 0, `rts_o` equals `mcr_rts_i` at all times, including while a frame is on the line.
- R3: Direction control is on when mode bit 4 is 1 and the divisor is nonzero. In that case, a write to offset 0x00 drives `rts_o` to its transmit level in the clock cycle right after the write is sampled.
- R4: The start bit begins exactly one bit time after the clock edge that samples the data write. One bit time is divisor × 16 clocks, or divisor × 13 clocks when mode bit 0 is 1. `txd_o` changes only on bit boundaries.
- R5: Each frame is sent on `txd_o` in this order: a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. The idle line is 1.
- R6: After the stop bit ends with no byte waiting, `rts_o` keeps its transmit level for exactly 3 more bit times and then returns to the receive level.
- R7: Mode bit 3 sets the polarity. When it is 0, `rts_o` is 0 during transmission and 1 otherwise. When it is 1, `rts_o` is 1 during transmission and 0 otherwise.
- R8: A byte written during the 3-bit guard cancels the guard. `rts_o` never leaves its transmit level, and the new start bit begins at the next bit boundary.
- R9: The holding register stores one byte. A byte written while a frame is shifting goes out directly after that frame's stop bit, with no idle bit between the frames. A write made while the holding register is already full is discarded.
- R10: While the divisor is zero, no bit ticks occur and `txd_o` holds its value. The direction output stays at its receive level. A pending byte waits until the divisor becomes nonzero, and its start bit begins one bit time after the divisor write.
- R11: `tx_idle_o` is 1 only when the holding register is empty, the shifter is empty, and the guard time has expired.
- R12: A mode write takes effect in the next cycle. Clearing bit 4 in the middle of a frame makes `rts_o` equal `mcr_rts_i` at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write offset |
| wr_data_i | input | 16 | Register write data |
| mcr_rts_i | input | 1 | Ordinary modem-control RTS value |
| txd_o | output | 1 | Serial transmit line |
| rts_o | output | 1 | RTS pin, used as the driver enable when direction control is on |
| tx_idle_o | output | 1 | Transmitter fully idle, including the guard time |

## Verification
Single frames are sent with 16x and 13x oversampling, with divisors of 1 and 2, and with both polarities. These runs separate the bit-time arithmetic from the lead-in and release timing, and they separate each polarity from the other. Other patterns exercise the holding register: a second write during a frame and a third write while the holding register is full show the back-to-back hand-off and the discard. A write landing inside the guard window shows whether the driver enable drops for even one cycle. Zero-divisor writes, enable-off passthrough, and polarity or enable changes in the middle of a frame show that direction follows configuration immediately and does not wait for the frame to end.

// File: rtl/rs485_pkg.sv
package rs485_pkg;

    // register offsets
    localparam int ADR_TXDATA  = 'h00;
    localparam int ADR_DIVISOR = 'h08;
    localparam int ADR_MODE    = 'h20;

    // mode register bit positions
    localparam int MODE_EN_BIT   = 4;
    localparam int MODE_POL_BIT  = 3;
    localparam int MODE_OS13_BIT = 0;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_GUARD = 2'd2
    } tx_state_e;

endpackage

// File: rtl/rs485_regs.sv
module rs485_regs
    import rs485_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DIV_W     = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DIV_W-1:0]     wr_data_i,
    output logic                 mode_en_o,
    output logic                 mode_pol_o,
    output logic                 mode_os13_o,
    output logic [DIV_W-1:0]     div_o,
    output logic                 thr_wr_o,
    output logic [DATA_BITS-1:0] thr_data_o
);

    typedef struct packed {
        logic             en;
        logic             pol;
        logic             os13;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic hit_mode, hit_div, hit_data;

    always_comb begin
        hit_mode = wr_en_i && (wr_addr_i == ADDR_W'(ADR_MODE));
        hit_div  = wr_en_i && (wr_addr_i == ADDR_W'(ADR_DIVISOR));
        hit_data = wr_en_i && (wr_addr_i == ADDR_W'(ADR_TXDATA));

        cfg_d = cfg_q;
        if (hit_mode) begin
            cfg_d.en   = wr_data_i[MODE_EN_BIT];
            cfg_d.pol  = wr_data_i[MODE_POL_BIT];
            cfg_d.os13 = wr_data_i[MODE_OS13_BIT];
        end
        if (hit_div) begin
            cfg_d.div = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_en_o   = cfg_q.en;
    assign mode_pol_o  = cfg_q.pol;
    assign mode_os13_o = cfg_q.os13;
    assign div_o       = cfg_q.div;
    assign thr_wr_o    = hit_data;
    assign thr_data_o  = wr_data_i[DATA_BITS-1:0];

endmodule

// File: rtl/rs485_baud.sv
module rs485_baud #(
    parameter int DIV_W  = 16,
    parameter int OS_HI  = 16,
    parameter int OS_LO  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             os13_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam int PRE_W = (OS_HI > 1) ? $clog2(OS_HI) : 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] dv;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    logic [PRE_W-1:0] pre_last;
    logic             pre_wrap;
    logic             dv_wrap;

    always_comb begin
        pre_last = os13_i ? PRE_W'(OS_LO - 1) : PRE_W'(OS_HI - 1);
        pre_wrap = (cnt_q.pre >= pre_last);
        dv_wrap  = (cnt_q.dv >= (div_i - DIV_W'(1)));
        tick_o   = run_i && pre_wrap && dv_wrap;

        cnt_d = cnt_q;
        if (!run_i) begin
            // timer rests at zero so a fresh frame gets a full lead-in bit
            cnt_d = '0;
        end else if (pre_wrap) begin
            cnt_d.pre = '0;
            cnt_d.dv  = dv_wrap ? '0 : cnt_q.dv + DIV_W'(1);
        end else begin
            cnt_d.pre = cnt_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/rs485_txeng.sv
module rs485_txeng
    import rs485_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int GUARD_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 div_nz_i,
    input  logic                 thr_wr_i,
    input  logic [DATA_BITS-1:0] thr_data_i,
    output logic                 txd_o,
    output logic                 line_busy_o,
    output logic                 idle_o
);

    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int GRD_W      = $clog2(GUARD_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(FRAME_BITS - 1);
    localparam logic [GRD_W-1:0] GUARD_INIT = GRD_W'(GUARD_BITS);

    typedef struct packed {
        tx_state_e               state;
        logic [DATA_BITS-1:0]    hold;
        logic                    hold_full;
        logic [FRAME_BITS-1:0]   shreg;
        logic [CNT_W-1:0]        bitcnt;
        logic [GRD_W-1:0]        guard;
    } eng_t;

    eng_t eng_d, eng_q;
    logic take;

    always_comb begin
        eng_d = eng_q;
        take  = 1'b0;

        if (thr_wr_i && !eng_q.hold_full) begin
            eng_d.hold_full = 1'b1;
            eng_d.hold      = thr_data_i;
        end

        if (tick_i) begin
            unique case (eng_q.state)
                TX_IDLE: begin
                    take = eng_q.hold_full;
                end
                TX_SHIFT: begin
                    if (eng_q.bitcnt == LAST_BIT) begin
                        if (eng_q.hold_full) begin
                            take = 1'b1;
                        end else begin
                            eng_d.state = TX_GUARD;
                            eng_d.guard = GUARD_INIT;
                        end
                    end else begin
                        eng_d.shreg  = {1'b1, eng_q.shreg[FRAME_BITS-1:1]};
                        eng_d.bitcnt = eng_q.bitcnt + CNT_W'(1);
                    end
                end
                TX_GUARD: begin
                    if (eng_q.hold_full) begin
                        take = 1'b1;
                    end else if (eng_q.guard <= GRD_W'(1)) begin
                        eng_d.state = TX_IDLE;
                        eng_d.guard = '0;
                    end else begin
                        eng_d.guard = eng_q.guard - GRD_W'(1);
                    end
                end
                default: begin
                    eng_d.state = TX_IDLE;
                end
            endcase
        end

        if (take) begin
            eng_d.state     = TX_SHIFT;
            eng_d.shreg     = {1'b1, eng_q.hold, 1'b0};
            eng_d.bitcnt    = '0;
            eng_d.hold_full = 1'b0;
            eng_d.guard     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign txd_o       = (eng_q.state == TX_SHIFT) ? eng_q.shreg[0] : 1'b1;
    assign line_busy_o = div_nz_i && (eng_q.hold_full || (eng_q.state != TX_IDLE));
    assign idle_o      = !eng_q.hold_full && (eng_q.state == TX_IDLE);

endmodule

// File: rtl/rs485_dir_tx.sv
module rs485_dir_tx #(
    parameter int ADDR_W     = 6,
    parameter int DIV_W      = 16,
    parameter int DATA_BITS  = 8,
    parameter int GUARD_BITS = 3,
    parameter int OS_HI      = 16,
    parameter int OS_LO      = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DIV_W-1:0]  wr_data_i,
    input  logic              mcr_rts_i,
    output logic              txd_o,
    output logic              rts_o,
    output logic              tx_idle_o
);

    logic                 mode_en;
    logic                 mode_pol;
    logic                 mode_os13;
    logic [DIV_W-1:0]     div_val;
    logic                 div_zero;
    logic                 thr_wr;
    logic [DATA_BITS-1:0] thr_data;
    logic                 bit_tick;
    logic                 dir_active;

    rs485_regs #(
        .ADDR_W    (ADDR_W),
        .DIV_W     (DIV_W),
        .DATA_BITS (DATA_BITS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .mode_en_o   (mode_en),
        .mode_pol_o  (mode_pol),
        .mode_os13_o (mode_os13),
        .div_o       (div_val),
        .thr_wr_o    (thr_wr),
        .thr_data_o  (thr_data)
    );

    assign div_zero = (div_val == '0);

    rs485_baud #(
        .DIV_W (DIV_W),
        .OS_HI (OS_HI),
        .OS_LO (OS_LO)
    ) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (dir_active),
        .os13_i (mode_os13),
        .div_i  (div_val),
        .tick_o (bit_tick)
    );

    rs485_txeng #(
        .DATA_BITS  (DATA_BITS),
        .GUARD_BITS (GUARD_BITS)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (bit_tick),
        .div_nz_i    (!div_zero),
        .thr_wr_i    (thr_wr),
        .thr_data_i  (thr_data),
        .txd_o       (txd_o),
        .line_busy_o (dir_active),
        .idle_o      (tx_idle_o)
    );

    // polarity 0: low while sending; polarity 1: high while sending
    assign rts_o = mode_en ? (dir_active ? mode_pol : !mode_pol) : mcr_rts_i;

endmodule

// File: rtl/rs485_dir_chk.sv
module rs485_dir_chk (
    input logic clk,
    input logic rst_n,
    input logic rts_o,
    input logic txd_o,
    input logic tx_idle_o,
    input logic mcr_rts_i,
    input logic mode_en,
    input logic div_zero,
    input logic dir_active,
    input logic bit_tick,
    input logic thr_wr
);

    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |-> (rts_o == mcr_rts_i));

    assert_lead_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !div_zero) |=> dir_active);

    assert_bit_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd_o) |-> $past(bit_tick));

    assert_release_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dir_active) && !div_zero) |-> $past(bit_tick));

    assert_div_zero_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> !dir_active);

    assert_div_zero_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |=> $stable(txd_o));

    assert_idle_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle_o |-> (txd_o && !dir_active));

    assert_enable_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_en) |-> (rts_o == mcr_rts_i));

endmodule

bind rs485_dir_tx rs485_dir_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rts_o      (rts_o),
    .txd_o      (txd_o),
    .tx_idle_o  (tx_idle_o),
    .mcr_rts_i  (mcr_rts_i),
    .mode_en    (mode_en),
    .div_zero   (div_zero),
    .dir_active (dir_active),
    .bit_tick   (bit_tick),
    .thr_wr     (thr_wr)
);

// File: tb/tb_rs485_dir_tx.sv
module tb_rs485_dir_tx;

    localparam int CLK_NS = 10;
    localparam logic [5:0] A_DATA = 6'h00;
    localparam logic [5:0] A_DIV  = 6'h08;
    localparam logic [5:0] A_MODE = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [15:0] wr_data;
    logic        mcr_rts;
    logic        txd_o, rts_o, tx_idle_o;

    int n_total = 0;
    int n_bad   = 0;
    int tnow    = 0;
    logic mon_on  = 1'b0;
    logic mon_lvl = 1'b0;
    int   mon_bad = 0;

    rs485_dir_tx dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .mcr_rts_i (mcr_rts),
        .txd_o     (txd_o),
        .rts_o     (rts_o),
        .tx_idle_o (tx_idle_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(negedge clk) begin
        if (mon_on && (rts_o !== mon_lvl)) mon_bad++;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        tnow += n;
    endtask

    task automatic go(input int t);
        if (t > tnow) step(t - tnow);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); tnow++;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); tnow++;
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic en, input logic pol, input logic os13);
        wr(A_MODE, {11'b0, en, pol, 2'b0, os13});
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_frame(input logic [7:0] b, input int bt, input int s, input string req);
        go(s - 1);
        chk(req, "line high before start", 32'(txd_o), 32'd1);
        for (int i = 0; i < 10; i++) begin
            logic exp_bit;
            exp_bit = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
            go(s + i * bt + bt / 2);
            chk(req, $sformatf("frame bit %0d", i), 32'(txd_o), 32'(exp_bit));
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            if (tx_idle_o) break;
            step(1);
        end
    endtask

    task automatic t_reset();
        chk("R1", "txd after reset", 32'(txd_o), 32'd1);
        chk("R1", "idle after reset", 32'(tx_idle_o), 32'd1);
        mcr_rts = 1'b1; step(1);
        chk("R1", "rts follows mcr=1", 32'(rts_o), 32'd1);
        mcr_rts = 1'b0; step(1);
        chk("R1", "rts follows mcr=0", 32'(rts_o), 32'd0);
    endtask

    task automatic t_disabled();
        int w;
        mcr_rts = 1'b1;
        wr(A_DIV, 16'd1);
        set_mode(1'b0, 1'b0, 1'b0);
        wr(A_DATA, 16'h00C6); w = tnow;
        go(w + 16);
        chk("R2", "frame still starts", 32'(txd_o), 32'd0);
        go(w + 5 * 16);
        chk("R2", "rts = mcr 1 mid-frame", 32'(rts_o), 32'd1);
        mcr_rts = 1'b0; step(1);
        chk("R2", "rts = mcr 0 mid-frame", 32'(rts_o), 32'd0);
        wait_idle();
    endtask

    task automatic t_frame(input logic [7:0] b, input int dv, input logic os13,
                           input logic pol, input string req);
        int w, bt;
        bt = dv * (os13 ? 13 : 16);
        wr(A_DIV, 16'(dv));
        set_mode(1'b1, pol, os13);
        step(1);
        chk("R7", "receive level before send", 32'(rts_o), 32'(!pol));
        wr(A_DATA, {8'h00, b}); w = tnow;
        chk("R3", "direction on after write", 32'(rts_o), 32'(pol));
        chk("R11", "busy after write", 32'(tx_idle_o), 32'd0);
        chk_frame(b, bt, w + bt, req);
        go(w + 12 * bt);
        chk("R11", "not idle in guard", 32'(tx_idle_o), 32'd0);
        go(w + 14 * bt - 1);
        chk("R6", "held to guard end", 32'(rts_o), 32'(pol));
        step(1);
        chk("R6", "released after guard", 32'(rts_o), 32'(!pol));
        chk("R11", "idle after guard", 32'(tx_idle_o), 32'd1);
    endtask

    task automatic t_guard_cancel();
        int w;
        wr(A_DIV, 16'd1);
        set_mode(1'b1, 1'b0, 1'b0);
        wr(A_DATA, 16'h0055); w = tnow;
        mon_bad = 0; mon_lvl = 1'b0; mon_on = 1'b1;
        go(w + 12 * 16 + 2);
        wr(A_DATA, 16'h00C3);
        chk_frame(8'hC3, 16, w + 13 * 16, "R8");
        go(w + 26 * 16 - 1);
        mon_on = 1'b0;
        chk("R8", "rts dropouts", 32'(mon_bad), 32'd0);
        step(1);
        chk("R8", "released after second guard", 32'(rts_o), 32'd1);
    endtask

    task automatic t_drop();
        int w;
        wr(A_DIV, 16'd1);
        set_mode(1'b1, 1'b0, 1'b0);
        wr(A_DATA, 16'h000F); w = tnow;
        go(w + 2 * 16);
        wr(A_DATA, 16'h00F0);
        wr(A_DATA, 16'h0099);
        chk_frame(8'hF0, 16, w + 11 * 16, "R9");
        go(w + 24 * 16 - 1);
        chk("R9", "held before release", 32'(rts_o), 32'd0);
        step(1);
        chk("R9", "released, third byte gone", 32'(rts_o), 32'd1);
        chk("R9", "idle, third byte gone", 32'(tx_idle_o), 32'd1);
        step(40);
        chk("R9", "line stays high", 32'(txd_o), 32'd1);
    endtask

    task automatic t_divzero();
        int wd;
        wr(A_DIV, 16'd0);
        set_mode(1'b1, 1'b0, 1'b0);
        wr(A_DATA, 16'h005A);
        step(100);
        chk("R10", "txd held", 32'(txd_o), 32'd1);
        chk("R10", "direction off", 32'(rts_o), 32'd1);
        chk("R11", "pending byte not idle", 32'(tx_idle_o), 32'd0);
        wr(A_DIV, 16'd1); wd = tnow;
        chk("R10", "direction on once divisor set", 32'(rts_o), 32'd0);
        chk_frame(8'h5A, 16, wd + 16, "R10");
        go(wd + 14 * 16);
        chk("R10", "idle after frame", 32'(tx_idle_o), 32'd1);
    endtask

    task automatic t_en_clear();
        int w;
        mcr_rts = 1'b1;
        wr(A_DIV, 16'd1);
        set_mode(1'b1, 1'b0, 1'b0);
        wr(A_DATA, 16'h0081); w = tnow;
        go(w + 3 * 16);
        chk("R12", "active low mid-frame", 32'(rts_o), 32'd0);
        set_mode(1'b1, 1'b1, 1'b0);
        chk("R12", "polarity flip mid-frame", 32'(rts_o), 32'd1);
        set_mode(1'b0, 1'b1, 1'b0);
        mcr_rts = 1'b0; step(1);
        chk("R12", "enable cleared gives mcr", 32'(rts_o), 32'd0);
        wait_idle();
        chk("R12", "frame completes", 32'(tx_idle_o), 32'd1);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_bad++;
        $display("FAIL watchdog R1-scope run hung: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; mcr_rts = 1'b0;
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_disabled();
        t_frame(8'hA5, 1, 1'b0, 1'b0, "R4 R5");
        t_frame(8'h3C, 2, 1'b1, 1'b1, "R4 R5 R7");
        t_guard_cancel();
        t_drop();
        t_divzero();
        t_en_clear();
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule